// File: doc/BRIEF.md
# Byte-Stream 8-Bit Processor Core

This block is a small 8-bit processor. It reads its program one byte per cycle from a byte-wide instruction memory with a synchronous read port. Instructions are one to three bytes long, so the program counter moves forward by the length of each instruction rather than by a fixed stride. The core holds eight 8-bit working registers and a zero flag. It supports four operations: load an immediate byte into a register, add one register into another, jump to an absolute address, and jump to an absolute address only when the zero flag is clear.

A small sequencer takes the opcode byte and then the operand bytes in order. In a register operand byte the register numbers sit in nibbles. A jump target follows the opcode as two bytes, low byte first. Once the last byte of an instruction has arrived, the instruction completes in the next cycle. A one-cycle retire pulse marks its completion. If the core meets an opcode it does not know, or a register number that does not exist, it stops fetching and raises a halt output. A debug select input gives read access to any register, and the program counter and zero flag are visible as outputs, so the core can be watched from outside.

Top module: `bytecode_cpu`

## Requirements
- R1: While reset is held, pc_o reads 0x0010, imem_addr reads 0x0010, all eight registers and zero_o read 0, and halted and retire read 0.
- R2: Bytes AA, d0, ii load register d (the high nibble of the second byte) with ii. pc_o then advances by 3 and zero_o is unchanged. The low nibble of the second byte is not used.
- R3: Bytes B2, xy set register x to (rx + ry) mod 256, where x is the high nibble and y the low nibble. pc_o then advances by 2.
- R4: zero_o changes only when an add retires. It becomes 1 exactly when the 8-bit sum is 0x00.
- R5: Bytes C3, lo, hi set pc_o to {hi, lo}.
- R6: Bytes C2, lo, hi set pc_o to {hi, lo} when zero_o is 0. Otherwise they set pc_o to pc_o + 3.
- R7: Any opcode other than AA, B2, C3 or C2 raises halted two cycles after the instruction starts. halted then stays high, pc_o holds, and retire stays low.
- R8: A register nibble of 8 or more halts the core three cycles after the instruction starts, and no register is written. This covers the destination nibble of a load and either nibble of an add.
- R9: retire is high for exactly one cycle per instruction, len + 2 cycles after the instruction starts, and pc_o changes only in that cycle.
- R10: An instruction at address p presents p, p+1, … p+len-1 on imem_addr in its first len cycles. In the retire cycle, imem_addr equals the new pc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 16 | Instruction memory byte address |
| imem_data | input | 8 | Byte read from imem_addr, valid one cycle later |
| halted | output | 1 | Core stopped on an illegal encoding |
| retire | output | 1 | One-cycle pulse when an instruction completes |
| pc_o | output | 16 | Address of the instruction now being fetched |
| zero_o | output | 1 | Zero flag |
| dbg_sel | input | 3 | Register index for debug read |
| dbg_data | output | 8 | Contents of the selected register |

## Verification
The bench goes after the length-dependent PC step. A core that used a fixed stride would land in the middle of an instruction and fetch the wrong bytes. It checks that the little-endian jump target is assembled correctly; swapping the target bytes sends control to a wrong address. It drives the not-zero jump both ways, taken and falling through, so an inverted condition breaks the loop count. It checks that the flag survives loads, since a load that touched the flag would flip a later branch. It also makes sure illegal encodings halt at the cycle given in R7 and R8 and leave the registers untouched. A core that checked too late would write a register that does not exist or retire a bad instruction.

// File: rtl/bytecode_cpu_pkg.sv
package bytecode_cpu_pkg;

   localparam logic [7:0] OPC_LDI = 8'hAA;
   localparam logic [7:0] OPC_ADD = 8'hB2;
   localparam logic [7:0] OPC_JMP = 8'hC3;
   localparam logic [7:0] OPC_JNZ = 8'hC2;

   typedef enum logic [2:0] {
      ST_REQ,
      ST_OP,
      ST_B1,
      ST_B2,
      ST_EXEC,
      ST_HALT
   } seq_state_e;

   typedef enum logic [2:0] {
      K_LDI,
      K_ADD,
      K_JMP,
      K_JNZ,
      K_BAD
   } op_kind_e;

   function automatic op_kind_e classify(input logic [7:0] b);
      case (b)
         OPC_LDI: return K_LDI;
         OPC_ADD: return K_ADD;
         OPC_JMP: return K_JMP;
         OPC_JNZ: return K_JNZ;
         default: return K_BAD;
      endcase
   endfunction

   function automatic logic [1:0] op_len(input op_kind_e k);
      case (k)
         K_ADD:                return 2'd2;
         K_LDI, K_JMP, K_JNZ:  return 2'd3;
         default:              return 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/bytecode_cpu_decode.sv
module bytecode_cpu_decode
   import bytecode_cpu_pkg::*;
#(
   parameter int NREGS = 8,
   parameter int IDX_W = 3
) (
   input  logic [7:0]       op_byte,
   input  logic [7:0]       fld_byte,
   output op_kind_e         kind,
   output logic [1:0]       len,
   output logic             bad_reg,
   output logic [IDX_W-1:0] ix,
   output logic [IDX_W-1:0] iy
);

   logic x_bad;
   logic y_bad;

   always_comb begin
      kind  = classify(op_byte);
      len   = op_len(kind);
      x_bad = int'(fld_byte[7:4]) >= NREGS;
      y_bad = int'(fld_byte[3:0]) >= NREGS;
      case (kind)
         K_LDI:   bad_reg = x_bad;
         K_ADD:   bad_reg = x_bad | y_bad;
         default: bad_reg = 1'b0;
      endcase
      ix = fld_byte[4 +: IDX_W];
      iy = fld_byte[0 +: IDX_W];
   end

endmodule

// File: rtl/bytecode_cpu_regfile.sv
module bytecode_cpu_regfile #(
   parameter int DATA_W         = 8,
   parameter int NREGS          = 8,
   parameter int IDX_W          = 3,
   parameter bit DBG_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra,
   input  logic [IDX_W-1:0]  rb,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   input  logic [IDX_W-1:0]  dsel,
   output logic [DATA_W-1:0] ddata
);

   logic [DATA_W-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (we && (int'(waddr) == i))
            regs[i] <= wdata;
      end
   end

   assign rd_a = regs[ra];
   assign rd_b = regs[rb];

   if (DBG_REGISTERED) begin : g_dbg_ff
      always_ff @(posedge clk) begin
         if (!rst_n)
            ddata <= '0;
         else
            ddata <= regs[dsel];
      end
   end else begin : g_dbg_comb
      assign ddata = regs[dsel];
   end

endmodule

// File: rtl/bytecode_cpu_seq.sv
module bytecode_cpu_seq
   import bytecode_cpu_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(16'h0010)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        imem_data,
   input  op_kind_e          dec_kind,
   input  logic [1:0]        dec_len,
   input  logic              dec_bad_reg,
   input  logic              zero_flag,
   output logic [7:0]        dec_op_byte,
   output logic [7:0]        dec_fld_byte,
   output seq_state_e        state,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] fptr,
   output op_kind_e          kind_q,
   output logic [7:0]        imm_q,
   output logic              exec,
   output logic              retire,
   output logic              halted
);

   logic [7:0]        opc_q;
   logic [7:0]        fld_q;
   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] pc_step;
   logic [ADDR_W-1:0] pc_next;

   always_comb begin
      kind_q       = classify(opc_q);
      dec_op_byte  = (state == ST_OP) ? imem_data : opc_q;
      dec_fld_byte = (state == ST_B1) ? imem_data : fld_q;
      target       = ADDR_W'({imm_q, fld_q});
      pc_step      = pc + ADDR_W'(op_len(kind_q));
      case (kind_q)
         K_JMP:   pc_next = target;
         K_JNZ:   pc_next = zero_flag ? pc_step : target;
         default: pc_next = pc_step;
      endcase
      exec   = (state == ST_EXEC);
      halted = (state == ST_HALT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_REQ;
         pc     <= RESET_PC;
         fptr   <= RESET_PC;
         opc_q  <= '0;
         fld_q  <= '0;
         imm_q  <= '0;
         retire <= 1'b0;
      end else begin
         retire <= 1'b0;
         case (state)
            ST_REQ: begin
               fptr  <= fptr + ADDR_W'(1);
               state <= ST_OP;
            end
            ST_OP: begin
               opc_q <= imem_data;
               if (dec_kind == K_BAD)
                  state <= ST_HALT;
               else if (dec_len == 2'd1)
                  state <= ST_EXEC;
               else begin
                  fptr  <= fptr + ADDR_W'(1);
                  state <= ST_B1;
               end
            end
            ST_B1: begin
               fld_q <= imem_data;
               if (dec_bad_reg)
                  state <= ST_HALT;
               else if (dec_len == 2'd2)
                  state <= ST_EXEC;
               else begin
                  fptr  <= fptr + ADDR_W'(1);
                  state <= ST_B2;
               end
            end
            ST_B2: begin
               imm_q <= imem_data;
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               pc     <= pc_next;
               fptr   <= pc_next;
               retire <= 1'b1;
               state  <= ST_REQ;
            end
            ST_HALT: state <= ST_HALT;
            default: state <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/bytecode_cpu.sv
module bytecode_cpu
   import bytecode_cpu_pkg::*;
#(
   parameter int                ADDR_W         = 16,
   parameter int                NREGS          = 8,
   parameter logic [ADDR_W-1:0] RESET_PC       = ADDR_W'(16'h0010),
   parameter bit                DBG_REGISTERED = 1'b0,
   localparam int               DATA_W         = 8,
   localparam int               IDX_W          = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [DATA_W-1:0] imem_data,
   output logic              halted,
   output logic              retire,
   output logic [ADDR_W-1:0] pc_o,
   output logic              zero_o,
   input  logic [IDX_W-1:0]  dbg_sel,
   output logic [DATA_W-1:0] dbg_data
);

   if (ADDR_W < 16) begin : g_chk_addr
      $error("bytecode_cpu: ADDR_W must hold a 16-bit jump target");
   end
   if (NREGS < 2 || NREGS > 16) begin : g_chk_regs
      $error("bytecode_cpu: NREGS must fit a 4-bit register field");
   end

   seq_state_e        state;
   op_kind_e          dec_kind;
   op_kind_e          kind_q;
   logic [1:0]        dec_len;
   logic              dec_bad_reg;
   logic [7:0]        dec_op_byte;
   logic [7:0]        dec_fld_byte;
   logic [7:0]        imm_q;
   logic [IDX_W-1:0]  ix;
   logic [IDX_W-1:0]  iy;
   logic              exec;
   logic              zero_q;
   logic [DATA_W-1:0] rd_a;
   logic [DATA_W-1:0] rd_b;
   logic [DATA_W-1:0] sum;
   logic              we;
   logic [DATA_W-1:0] wdata;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] fptr;

   bytecode_cpu_seq #(
      .ADDR_W   (ADDR_W),
      .RESET_PC (RESET_PC)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .imem_data    (imem_data),
      .dec_kind     (dec_kind),
      .dec_len      (dec_len),
      .dec_bad_reg  (dec_bad_reg),
      .zero_flag    (zero_q),
      .dec_op_byte  (dec_op_byte),
      .dec_fld_byte (dec_fld_byte),
      .state        (state),
      .pc           (pc),
      .fptr         (fptr),
      .kind_q       (kind_q),
      .imm_q        (imm_q),
      .exec         (exec),
      .retire       (retire),
      .halted       (halted)
   );

   bytecode_cpu_decode #(
      .NREGS (NREGS),
      .IDX_W (IDX_W)
   ) u_dec (
      .op_byte  (dec_op_byte),
      .fld_byte (dec_fld_byte),
      .kind     (dec_kind),
      .len      (dec_len),
      .bad_reg  (dec_bad_reg),
      .ix       (ix),
      .iy       (iy)
   );

   always_comb begin
      sum   = rd_a + rd_b;
      we    = exec && (kind_q == K_LDI || kind_q == K_ADD);
      wdata = (kind_q == K_LDI) ? imm_q : sum;
   end

   bytecode_cpu_regfile #(
      .DATA_W         (DATA_W),
      .NREGS          (NREGS),
      .IDX_W          (IDX_W),
      .DBG_REGISTERED (DBG_REGISTERED)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (ix),
      .wdata (wdata),
      .ra    (ix),
      .rb    (iy),
      .rd_a  (rd_a),
      .rd_b  (rd_b),
      .dsel  (dbg_sel),
      .ddata (dbg_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         zero_q <= 1'b0;
      else if (exec && kind_q == K_ADD)
         zero_q <= (sum == '0);
   end

   assign imem_addr = fptr;
   assign pc_o      = pc;
   assign zero_o    = zero_q;

endmodule

// File: rtl/bytecode_cpu_chk.sv
module bytecode_cpu_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] imem_addr,
   input logic              retire,
   input logic              halted,
   input logic              zero_o
);

   // R7: once stopped, the core never restarts without reset
   a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R7: a stopped core holds its PC and retires nothing
   a_r7_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> ($stable(pc_o) && !retire));

   // R9: retire is a single-cycle pulse
   a_r9_retire_single: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire);

   // R9: the PC moves only together with a retire
   a_r9_pc_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc_o) |-> retire);

   // R4: the flag moves only together with a retire
   a_r4_zero_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(zero_o) |-> retire);

   // R10: fetch restarts at the new PC
   a_r10_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> (imem_addr == pc_o));

endmodule

bind bytecode_cpu bytecode_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc_o      (pc_o),
   .imem_addr (imem_addr),
   .retire    (retire),
   .halted    (halted),
   .zero_o    (zero_o)
);

// File: tb/bytecode_cpu_bench.sv
module bytecode_cpu_bench;

   localparam int CLK_PERIOD = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] imem_addr;
   logic [7:0]  imem_data;
   logic        halted;
   logic        retire;
   logic [15:0] pc_o;
   logic        zero_o;
   logic [2:0]  dbg_sel = '0;
   logic [7:0]  dbg_data;

   logic [7:0]  mem [256];

   int n_cmp = 0;
   int n_bad = 0;

   logic [7:0]  m_r [8];
   logic        m_z;
   logic [15:0] m_pc;
   logic [7:0]  m_op;
   int          m_len;
   int          m_halt_at;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) imem_data <= mem[imem_addr[7:0]];

   bytecode_cpu u_bytecode_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .imem_addr (imem_addr),
      .imem_data (imem_data),
      .halted    (halted),
      .retire    (retire),
      .pc_o      (pc_o),
      .zero_o    (zero_o),
      .dbg_sel   (dbg_sel),
      .dbg_data  (dbg_data)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   endtask

   task automatic put(input int a, input logic [7:0] b);
      mem[a] = b;
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_r[i] = 8'h00;
      m_z  = 1'b0;
      m_pc = 16'h0010;
   endtask

   task automatic model_decode();
      logic [7:0] b1;
      m_op = mem[m_pc[7:0]];
      b1   = mem[8'(m_pc[7:0] + 8'd1)];
      m_halt_at = 0;
      case (m_op)
         8'hAA: begin m_len = 3; if (b1[7:4] > 4'd7) m_halt_at = 3; end
         8'hB2: begin m_len = 2; if (b1[7:4] > 4'd7 || b1[3:0] > 4'd7) m_halt_at = 3; end
         8'hC3, 8'hC2: m_len = 3;
         default: begin m_len = 1; m_halt_at = 2; end
      endcase
   endtask

   task automatic model_exec();
      logic [7:0] b1, b2, s;
      b1 = mem[8'(m_pc[7:0] + 8'd1)];
      b2 = mem[8'(m_pc[7:0] + 8'd2)];
      case (m_op)
         8'hAA: begin m_r[b1[6:4]] = b2; m_pc = m_pc + 16'd3; end
         8'hB2: begin
            s = m_r[b1[6:4]] + m_r[b1[2:0]];
            m_r[b1[6:4]] = s;
            m_z = (s == 8'h00);
            m_pc = m_pc + 16'd2;
         end
         8'hC3: m_pc = {b2, b1};
         8'hC2: m_pc = m_z ? m_pc + 16'd3 : {b2, b1};
         default: ;
      endcase
   endtask

   function automatic string kind_tag(input logic [7:0] op);
      case (op)
         8'hAA:   return "R2";
         8'hB2:   return "R3";
         8'hC3:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check_regs(input string tag);
      for (int i = 0; i < 8; i++) begin
         dbg_sel = 3'(i);
         #2;
         chk(tag, $sformatf("reg %0d", i), int'(dbg_data), int'(m_r[i]));
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_prog(input int max_instr);
      int    cyc;
      int    n;
      string tag;
      do_reset();
      model_reset();
      model_decode();
      chk("R10", "fetch addr at start", int'(imem_addr), int'(m_pc));
      cyc = 0;
      n   = 0;
      while (n < max_instr) begin
         @(negedge clk);
         cyc++;
         if (m_halt_at != 0) begin
            tag = (m_halt_at == 2) ? "R7" : "R8";
            if (cyc < m_halt_at)
               chk(tag, "halted early", int'(halted), 0);
            else begin
               chk(tag, "halted", int'(halted), 1);
               repeat (4) @(negedge clk);
               chk("R7", "halt stays", int'(halted), 1);
               chk("R7", "pc held", int'(pc_o), int'(m_pc));
               chk("R7", "no retire when halted", int'(retire), 0);
               check_regs(tag);
               return;
            end
         end else begin
            if (cyc < m_len)
               chk("R10", "fetch addr", int'(imem_addr), int'(m_pc) + cyc);
            if (cyc == m_len + 2) begin
               chk("R9", "retire", int'(retire), 1);
               tag = kind_tag(m_op);
               model_exec();
               chk(tag, "pc", int'(pc_o), int'(m_pc));
               chk("R4", "zero flag", int'(zero_o), int'(m_z));
               check_regs(tag);
               model_decode();
               chk("R10", "fetch addr after retire", int'(imem_addr), int'(m_pc));
               cyc = 0;
               n++;
            end else
               chk("R9", "no retire", int'(retire), 0);
         end
         if (cyc > 8) begin
            chk("R9", "instruction stalled", cyc, 0);
            return;
         end
      end
   endtask

   // R2 R3 R4: loads, adds, flag set by add, flag kept across loads, then R7 stop
   task automatic t_arith();
      clear_mem();
      put(16'h10, 8'hAA); put(16'h11, 8'h00); put(16'h12, 8'h02);
      put(16'h13, 8'hAA); put(16'h14, 8'h10); put(16'h15, 8'hFF);
      put(16'h16, 8'hB2); put(16'h17, 8'h01);
      put(16'h18, 8'hAA); put(16'h19, 8'h20); put(16'h1A, 8'h01);
      put(16'h1B, 8'hB2); put(16'h1C, 8'h12);
      put(16'h1D, 8'hAA); put(16'h1E, 8'h30); put(16'h1F, 8'h00);
      put(16'h20, 8'hAA); put(16'h21, 8'h70); put(16'h22, 8'h5A);
      put(16'h23, 8'hB2); put(16'h24, 8'h77);
      put(16'h25, 8'hB2); put(16'h26, 8'h33);
      put(16'h27, 8'hFF);
      run_prog(20);
   endtask

   // R1: reset after a program has left state behind
   task automatic t_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "pc in reset", int'(pc_o), 16'h0010);
      chk("R1", "addr in reset", int'(imem_addr), 16'h0010);
      chk("R1", "halted in reset", int'(halted), 0);
      chk("R1", "retire in reset", int'(retire), 0);
      chk("R1", "zero in reset", int'(zero_o), 0);
      model_reset();
      check_regs("R1");
      rst_n = 1'b1;
   endtask

   // R5 R6: absolute jump, then a countdown loop on the not-zero jump
   task automatic t_jump();
      clear_mem();
      put(16'h10, 8'hC3); put(16'h11, 8'h40); put(16'h12, 8'h00);
      put(16'h40, 8'hAA); put(16'h41, 8'h00); put(16'h42, 8'h03);
      put(16'h43, 8'hAA); put(16'h44, 8'h10); put(16'h45, 8'hFF);
      put(16'h46, 8'hB2); put(16'h47, 8'h01);
      put(16'h48, 8'hC2); put(16'h49, 8'h46); put(16'h4A, 8'h00);
      put(16'h4B, 8'h00);
      run_prog(20);
   endtask

   // R8: destination nibble out of range on a load
   task automatic t_bad_ldi();
      clear_mem();
      put(16'h10, 8'hAA); put(16'h11, 8'h00); put(16'h12, 8'h11);
      put(16'h13, 8'hAA); put(16'h14, 8'h80); put(16'h15, 8'h05);
      run_prog(10);
   endtask

   // R8: source nibble out of range on an add
   task automatic t_bad_add();
      clear_mem();
      put(16'h10, 8'hAA); put(16'h11, 8'h00); put(16'h12, 8'h11);
      put(16'h13, 8'hB2); put(16'h14, 8'h09);
      run_prog(10);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      clear_mem();
      t_arith();
      t_reset();
      t_jump();
      t_bad_ldi();
      t_bad_add();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule